// File: doc/BRIEF.md
# Clear-Only Flash Read Protection Register

This block holds one word of read-protection enables for a window of flash. Each bit stands for one fixed-size block of the flash (2 KB by default, 32 bits, so 64 KB of address space). A set bit allows reads from that block. Software can only take away read permission. Writing a 0 clears the matching bit. Writing a 1 leaves the bit as it was, so a cleared bit can never be set again by a write.

The block keeps two copies of the enables. The working copy takes every write and drives the read-allowed decision. The committed copy models the non-volatile store. It starts at all ones and only changes when a commit request arrives. A power-on reset reloads the working copy from the committed copy, which undoes any clear that was never committed. A system reset of any other kind leaves both copies alone and only clears the registered read-allowed output.

The block also decodes an incoming flash address. When the address lies inside the covered window, the block looks up the enable bit for the addressed block and presents the result one cycle later as `readOk`.

Top module: `flash_read_guard`

## Requirements
- R1: Before any commit, a power-on reset leaves `regValue` and `committedValue` both at all ones, and `readOk` at 0.
- R2: A write (`wrEn` high with `porRstN` high) sets `regValue` at the next rising edge to its old value ANDed with `wrData`. A 1 in `wrData` never turns a 0 bit back to 1.
- R3: A commit (`commitReq` high with `porRstN` high) sets `committedValue` at the next rising edge to its old value ANDed with the working value.
- R4: While `porRstN` is low at a rising edge, `regValue` is loaded from `committedValue`, and `wrEn` and `commitReq` are ignored.
- R5: A bit that was cleared and committed stays 0 after a power-on reset. A bit that was cleared but not committed returns to 1.
- R6: `sysRstN` low changes neither `regValue` nor `committedValue`.
- R7: One edge after `addr` is presented, `readOk` equals `regValue` bit `addr[15:11]` (bit index = block number) if `addr[31:16]` equals the window base (0x0001 by default, i.e. 64 KB to 128 KB). Otherwise `readOk` is 0.
- R8: `porRstN` or `sysRstN` low at a rising edge forces `readOk` to 0 after that edge.
- R9: `committedValue` never gains a 1 bit.
- R10: When a write and a commit occur in the same cycle, the commit stores the value that includes that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, active low, synchronous |
| sysRstN | input | 1 | Other system reset, active low; touches only `readOk` |
| wrEn | input | 1 | Write strobe for the working copy |
| wrData | input | 32 | Write data; a 0 bit clears the enable for its block |
| commitReq | input | 1 | Make the working copy permanent |
| addr | input | 32 | Flash byte address to check |
| regValue | output | 32 | Working copy of the enables |
| committedValue | output | 32 | Committed (non-volatile) copy |
| readOk | output | 1 | Read allowed for the address of the previous cycle |

## Verification
Each result of this block is due exactly one rising edge after its stimulus. This holds for the working copy after a write or restore, the committed copy after a commit, and `readOk` after an address or a reset. The bench changes inputs on the falling edge. It samples the outputs on the next falling edge, after the single register stage has updated. Cases that must show no effect, such as a write during power-on reset or a system reset, are judged from the same outputs on the falling edge that follows the stimulus.

// File: rtl/fprot_pkg.sv
package fprot_pkg;
  // Strobes from control to datapath, valid for the current cycle
  typedef struct packed {
    logic doWrite;    // AND write data into the working copy
    logic doCommit;   // AND the working copy into the committed copy
    logic doRestore;  // reload the working copy from the committed copy
    logic clrRead;    // force the registered read-allowed flag low
  } fprot_strobe_t;
endpackage

// File: rtl/fprot_ctrl.sv
module fprot_ctrl
  import fprot_pkg::*;
(
  input  logic          porRstN,
  input  logic          sysRstN,
  input  logic          wrEn,
  input  logic          commitReq,
  output fprot_strobe_t strb
);
  // A power-on reset overrides any software action in the same cycle
  always_comb begin
    strb.doRestore = !porRstN;
    strb.doWrite   = porRstN && wrEn;
    strb.doCommit  = porRstN && commitReq;
    strb.clrRead   = !porRstN || !sysRstN;
  end
endmodule

// File: rtl/fprot_lookup.sv
module fprot_lookup #(
  parameter int unsigned NUM_BLOCKS  = 32,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned OFFSET_BITS = 11,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0001_0000
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic [NUM_BLOCKS-1:0] enBits,
  output logic                  hit
);
  localparam int unsigned IDX_W   = $clog2(NUM_BLOCKS);
  localparam int unsigned WIN_LSB = OFFSET_BITS + IDX_W;

  logic [IDX_W-1:0]      blkIdx;
  logic                  inWindow;
  logic [NUM_BLOCKS-1:0] selHit;
  logic                  unusedOffset;

  assign blkIdx       = addr[WIN_LSB-1:OFFSET_BITS];
  assign inWindow     = (addr[ADDR_W-1:WIN_LSB] == WIN_BASE[ADDR_W-1:WIN_LSB]);
  assign unusedOffset = ^addr[OFFSET_BITS-1:0];

  // One-hot select per block, then OR-reduce
  generate
    for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_sel
      assign selHit[i] = (blkIdx == IDX_W'(i)) && enBits[i];
    end
  endgenerate

  assign hit = inWindow && (|selHit);
endmodule

// File: rtl/fprot_datapath.sv
module fprot_datapath
  import fprot_pkg::*;
#(
  parameter int unsigned NUM_BLOCKS  = 32,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned OFFSET_BITS = 11,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0001_0000
) (
  input  logic                  clk,
  input  logic                  porRstN,
  input  logic                  sysRstN,
  input  fprot_strobe_t         strb,
  input  logic [NUM_BLOCKS-1:0] wrData,
  input  logic [ADDR_W-1:0]     addr,
  output logic [NUM_BLOCKS-1:0] workVal,
  output logic [NUM_BLOCKS-1:0] persistVal,
  output logic                  readOk
);
  localparam int unsigned WIN_LSB = OFFSET_BITS + $clog2(NUM_BLOCKS);

  logic [NUM_BLOCKS-1:0] workReg;
  // Non-volatile copy: factory state all ones, no reset touches it
  logic [NUM_BLOCKS-1:0] persistReg = '1;
  logic [NUM_BLOCKS-1:0] workNext;
  logic                  readOkReg;
  logic                  lookupHit;

  always_comb begin
    workNext = workReg;
    if (strb.doRestore)    workNext = persistReg;
    else if (strb.doWrite) workNext = workReg & wrData;
  end

  always_ff @(posedge clk) begin
    workReg <= workNext;
    if (strb.doCommit) persistReg <= persistReg & workNext;
  end

  fprot_lookup #(
    .NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W),
    .OFFSET_BITS(OFFSET_BITS), .WIN_BASE(WIN_BASE)
  ) u_lookup (
    .addr(addr), .enBits(workReg), .hit(lookupHit)
  );

  always_ff @(posedge clk) begin
    if (strb.clrRead) readOkReg <= 1'b0;
    else              readOkReg <= lookupHit;
  end

  assign workVal    = workReg;
  assign persistVal = persistReg;
  assign readOk     = readOkReg;

  // R2: outside power-on reset the working copy never gains a 1 bit
  p_work_no_set_r2: assert property (@(posedge clk) disable iff (!porRstN)
    1'b1 |=> ((workReg & ~$past(workReg)) == '0));

  // R9: the committed copy never gains a 1 bit
  p_persist_no_set_r9: assert property (@(posedge clk) disable iff (!porRstN)
    1'b1 |=> ((persistReg & ~$past(persistReg)) == '0));

  // R4: a restore cycle loads the committed copy
  p_restore_load_r4: assert property (@(posedge clk) disable iff (!sysRstN)
    !porRstN |=> (workReg == $past(persistReg)));

  // R7: an address outside the window never grants a read
  p_outside_denied_r7: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    (addr[ADDR_W-1:WIN_LSB] != WIN_BASE[ADDR_W-1:WIN_LSB]) |=> !readOk);

  // R8: a system reset cycle leaves readOk low
  p_sysrst_clears_r8: assert property (@(posedge clk) disable iff (!porRstN)
    !sysRstN |=> !readOk);
endmodule

// File: rtl/flash_read_guard.sv
module flash_read_guard #(
  parameter int unsigned NUM_BLOCKS  = 32,
  parameter int unsigned BLOCK_BYTES = 2048,
  parameter int unsigned ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0001_0000
) (
  input  logic                  clk,
  input  logic                  porRstN,
  input  logic                  sysRstN,
  input  logic                  wrEn,
  input  logic [NUM_BLOCKS-1:0] wrData,
  input  logic                  commitReq,
  input  logic [ADDR_W-1:0]     addr,
  output logic [NUM_BLOCKS-1:0] regValue,
  output logic [NUM_BLOCKS-1:0] committedValue,
  output logic                  readOk
);
  import fprot_pkg::*;

  localparam int unsigned OFFSET_BITS = $clog2(BLOCK_BYTES);

  fprot_strobe_t strb;

  fprot_ctrl u_ctrl (
    .porRstN(porRstN), .sysRstN(sysRstN),
    .wrEn(wrEn), .commitReq(commitReq), .strb(strb)
  );

  fprot_datapath #(
    .NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W),
    .OFFSET_BITS(OFFSET_BITS), .WIN_BASE(WIN_BASE)
  ) u_dp (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .strb(strb),
    .wrData(wrData), .addr(addr),
    .workVal(regValue), .persistVal(committedValue), .readOk(readOk)
  );

  // R10: same-cycle write and commit store the written value
  p_commit_sees_write_r10: assert property (@(posedge clk) disable iff (!porRstN)
    (wrEn && commitReq) |=> ((committedValue & ~regValue) == '0));
endmodule

// File: tb/flash_read_guard_bench.sv
module flash_read_guard_bench;
  logic        clk = 1'b0;
  logic        porRstN = 1'b0;
  logic        sysRstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '1;
  logic        commitReq = 1'b0;
  logic [31:0] addr = '0;
  logic [31:0] regValue, committedValue;
  logic        readOk;

  int applied = 0;
  int miscompares = 0;
  int cycles = 0;

  always #2 clk = ~clk;  // 250 MHz

  flash_read_guard u_flash_read_guard (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .wrEn(wrEn),
    .wrData(wrData), .commitReq(commitReq), .addr(addr),
    .regValue(regValue), .committedValue(committedValue), .readOk(readOk)
  );

  // {wrEn, commitReq, wrData, expWork, expPersist}
  localparam logic [97:0] VEC [6] = '{
    {1'b1, 1'b0, 32'hFFFF_FF0F, 32'hFFFF_FF0F, 32'hFFFF_FFFF},  // R2 clear
    {1'b1, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FF0F, 32'hFFFF_FFFF},  // R2 no set
    {1'b1, 1'b0, 32'h0000_FFFF, 32'h0000_FF0F, 32'hFFFF_FFFF},  // R2
    {1'b1, 1'b1, 32'hFFFF_FFF0, 32'h0000_FF00, 32'h0000_FF00},  // R10/R3
    {1'b1, 1'b0, 32'hFFFF_F0FF, 32'h0000_F000, 32'h0000_FF00},  // R2 uncommitted
    {1'b0, 1'b0, 32'h0000_0000, 32'h0000_F000, 32'h0000_FF00}   // idle
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      miscompares++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    // Reset: both resets low for two edges
    @(negedge clk);
    step();
    step();
    check("R1 regValue", regValue, 32'hFFFF_FFFF);
    check("R1 committedValue", committedValue, 32'hFFFF_FFFF);
    check("R1 readOk", {31'd0, readOk}, 32'd0);
    porRstN = 1'b1;
    sysRstN = 1'b1;
    step();

    // Vector table
    for (int i = 0; i < 6; i++) begin
      {wrEn, commitReq, wrData} = VEC[i][97:64];
      step();
      check("R2/R3/R10 regValue", regValue, VEC[i][63:32]);
      check("R2/R3/R10 committedValue", committedValue, VEC[i][31:0]);
    end
    wrEn = 1'b0; commitReq = 1'b0;

    // R7 lookups on regValue = 0000_F000
    addr = 32'h0001_0000 | (32'd12 << 11); step();
    check("R7 in-window set bit", {31'd0, readOk}, 32'd1);
    addr = 32'h0001_0000 | (32'd8 << 11) | 32'h7FF; step();
    check("R7 in-window uncommitted clear", {31'd0, readOk}, 32'd0);
    addr = 32'h0000_0000 | (32'd12 << 11); step();
    check("R7 outside window", {31'd0, readOk}, 32'd0);

    // R6/R8 system reset: readOk cleared, copies untouched
    addr = 32'h0001_0000 | (32'd15 << 11);
    sysRstN = 1'b0; step();
    check("R8 readOk under sysRstN", {31'd0, readOk}, 32'd0);
    check("R6 regValue", regValue, 32'h0000_F000);
    check("R6 committedValue", committedValue, 32'h0000_FF00);
    sysRstN = 1'b1; step();
    check("R7 after sysRstN", {31'd0, readOk}, 32'd1);

    // R4/R5 power-on reset with write and commit held high
    wrEn = 1'b1; wrData = 32'h0; commitReq = 1'b1;
    porRstN = 1'b0; step();
    check("R4 restore regValue", regValue, 32'h0000_FF00);
    check("R4 commit ignored", committedValue, 32'h0000_FF00);
    check("R8 readOk under porRstN", {31'd0, readOk}, 32'd0);
    wrEn = 1'b0; commitReq = 1'b0; porRstN = 1'b1;
    addr = 32'h0001_0000 | (32'd8 << 11); step();
    check("R5 uncommitted clear restored", {31'd0, readOk}, 32'd1);
    addr = 32'h0001_0000 | (32'd16 << 11); step();
    check("R5 committed clear kept", {31'd0, readOk}, 32'd0);

    // R3 commit alone, then R9 no set via commit
    wrEn = 1'b1; wrData = 32'h0000_0F00; step();
    wrEn = 1'b0; commitReq = 1'b1; step();
    check("R3 commit", committedValue, 32'h0000_0F00);
    commitReq = 1'b0;
    porRstN = 1'b0; step();
    porRstN = 1'b1;
    wrEn = 1'b1; wrData = 32'hFFFF_FFFF; commitReq = 1'b1; step();
    check("R9 committedValue", committedValue, 32'h0000_0F00);
    check("R5 regValue after restore", regValue, 32'h0000_0F00);
    wrEn = 1'b0; commitReq = 1'b0;

    finishRun();
  end
endmodule